// File: doc/BRIEF.md
# Receive Page Buffer Controller

This block stores one incoming packet into a host-selected page of a byte-wide RAM and manages the host handshake around that page. The host issues an enable command that carries a page number. That command clears the receive-complete flag and chooses the page that the next packet lands in. Bytes arrive as a stream with start-of-packet and end-of-packet markers. The block writes them into the page in the same layout that a transmitting node uses, so a page that has been received can be sent again unchanged.

The first three bytes of a packet are the source ID, the destination ID and a count byte. A nonzero count byte is the start offset of a short message whose last byte falls on offset 255. When long packets are allowed, a zero count byte means a fourth header byte follows. That byte is the start offset of a long message whose last byte falls on offset 511 of a 512-byte page. Once a packet has been stored completely and correctly, the block sets the receive-complete flag. It can also pulse an interrupt.

Top module: `rx_page_buf`

## Requirements
- R1: After reset, `rx_full` is 1 (no page is enabled), `irq` is 0 and `ram_we` is 0.
- R2: A cycle with `cmd_en` high clears `rx_full` at the next clock edge and records `cmd_page` as the page for the next packet that starts.
- R3: While `rx_full` is 1, a packet that starts produces no RAM writes and leaves `rx_full` at 1. Bytes that arrive outside a packet are ignored.
- R4: The first byte of a packet goes to page offset 0, the second byte to offset 1 and the third (count) byte to offset 2.
- R5: When the count byte C is 3 or more and is not the long marker, the data bytes go to offsets C, C+1 and so on, up to 255. When C is 1 or 2, the remaining bytes of that packet are not written.
- R6: With `cfg_long` at 1 and a count byte of 0, the fourth byte E goes to offset 3 and the data bytes go to offsets E through 511. When E is below 4, the remaining bytes are dropped. With `cfg_long` at 1, a short packet still ends at offset 255.
- R7: With `cfg_long` at 0, a count byte of 0 is invalid. The rest of the packet is dropped and the packet does not complete.
- R8: Each accepted byte appears on the RAM port one cycle after it is sampled. Its address is page*256+offset when `cfg_long` is 0, and page*512+offset (modulo 2^ADDR_W) when `cfg_long` is 1.
- R9: A packet completes when its end-marked byte is written at the final offset (255 for short, 511 for long) with `rx_err` low. `rx_full` then rises in the same cycle that this final write appears on the RAM port.
- R10: A packet that ends early, runs past the final offset, or ends with `rx_err` high leaves `rx_full` at 0. Bytes past the final offset are not written.
- R11: When `int_mask` is 1, `irq` is a one-cycle pulse coincident with the rise of `rx_full`. When `int_mask` is 0, completion raises no `irq`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| rx_valid | input | 1 | Byte strobe for the incoming stream |
| rx_sop | input | 1 | Marks the first byte of a packet |
| rx_eop | input | 1 | Marks the last byte of a packet |
| rx_err | input | 1 | Valid with the end byte; the packet is bad |
| rx_data | input | 8 | Incoming byte |
| cmd_en | input | 1 | Host enable-receive command strobe |
| cmd_page | input | PAGE_W | Page carried by the enable command |
| cfg_long | input | 1 | Allows long packets and selects 512-byte pages |
| int_mask | input | 1 | Lets completion pulse the interrupt |
| ram_we | output | 1 | RAM write strobe |
| ram_addr | output | ADDR_W | RAM byte address |
| ram_wdata | output | 8 | RAM write data |
| rx_full | output | 1 | Receive-complete flag |
| irq | output | 1 | Completion interrupt pulse |

## Verification
The assertions take it for granted that `cfg_long` stays constant while a packet is in flight. They also assume `rx_eop` and `rx_err` are used only on strobed bytes, and that the host does not issue an enable in the same cycle that a packet completes. The stimulus changes `cfg_long` only between packets, when the stream is idle. It drives markers only together with `rx_valid` and spaces host commands away from packet ends. The bench model derives every expected address from the header bytes and the page rules alone.

// File: rtl/rxpb_pkg.sv
package rxpb_pkg;
  localparam int OFF_W = 9;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_DID,
    ST_CNT,
    ST_EXT,
    ST_DATA,
    ST_SKIP
  } rx_st_e;

  localparam logic [OFF_W-1:0] SHORT_LAST = 9'd255;
  localparam logic [OFF_W-1:0] LONG_LAST  = 9'd511;
  localparam logic [7:0]       SHORT_MIN  = 8'd3;
  localparam logic [7:0]       LONG_MIN   = 8'd4;
endpackage

// File: rtl/rxpb_parser.sv
module rxpb_parser
  import rxpb_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             rx_valid,
  input  logic             rx_sop,
  input  logic             rx_eop,
  input  logic             rx_err,
  input  logic [7:0]       rx_data,
  input  logic             cfg_long,
  input  logic             full_i,
  output logic             wr_en,
  output logic [OFF_W-1:0] wr_off,
  output logic             pkt_start,
  output logic             done
);
  rx_st_e           st_q, st_d;
  logic [OFF_W-1:0] off_q, off_d;
  logic             long_q, long_d;
  logic [OFF_W-1:0] last_off;

  assign last_off = long_q ? LONG_LAST : SHORT_LAST;

  always_comb begin
    st_d      = st_q;
    off_d     = off_q;
    long_d    = long_q;
    wr_en     = 1'b0;
    wr_off    = '0;
    pkt_start = 1'b0;
    done      = 1'b0;
    if (rx_valid) begin
      if (rx_sop) begin
        if (full_i) begin
          st_d = rx_eop ? ST_IDLE : ST_SKIP;
        end else begin
          wr_en     = 1'b1;
          pkt_start = 1'b1;
          long_d    = 1'b0;
          st_d      = rx_eop ? ST_IDLE : ST_DID;
        end
      end else begin
        unique case (st_q)
          ST_DID: begin
            wr_en  = 1'b1;
            wr_off = 9'd1;
            st_d   = ST_CNT;
          end
          ST_CNT: begin
            wr_en  = 1'b1;
            wr_off = 9'd2;
            if (rx_data == 8'd0 && cfg_long) begin
              long_d = 1'b1;
              st_d   = ST_EXT;
            end else if (rx_data < SHORT_MIN) begin
              st_d = ST_SKIP;
            end else begin
              off_d = {1'b0, rx_data};
              st_d  = ST_DATA;
            end
          end
          ST_EXT: begin
            wr_en  = 1'b1;
            wr_off = 9'd3;
            if (rx_data < LONG_MIN) begin
              st_d = ST_SKIP;
            end else begin
              off_d = {1'b0, rx_data};
              st_d  = ST_DATA;
            end
          end
          ST_DATA: begin
            wr_en  = 1'b1;
            wr_off = off_q;
            done   = rx_eop && !rx_err && (off_q == last_off);
            if (off_q == last_off) st_d = ST_SKIP;
            else                   off_d = off_q + 9'd1;
          end
          default: ;
        endcase
        if (rx_eop) st_d = ST_IDLE;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= ST_IDLE;
      off_q  <= '0;
      long_q <= 1'b0;
    end else if (rx_valid) begin
      st_q   <= st_d;
      off_q  <= off_d;
      long_q <= long_d;
    end
  end

  // R10
  wr_in_page_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |-> (wr_off <= last_off));

  // R3
  no_wr_when_full_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |-> !full_i);

  // R9
  done_on_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (wr_en && rx_eop));
endmodule

// File: rtl/rxpb_wr_port.sv
module rxpb_wr_port
  import rxpb_pkg::*;
#(
  parameter int PAGE_W = 3,
  parameter int ADDR_W = 11
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [OFF_W-1:0]  wr_off,
  input  logic [7:0]        wr_data,
  input  logic              pkt_start,
  input  logic [PAGE_W-1:0] page_sel,
  input  logic              cfg_long,
  output logic              ram_we,
  output logic [ADDR_W-1:0] ram_addr,
  output logic [7:0]        ram_wdata
);
  localparam int SUM_W = PAGE_W + OFF_W;

  logic [PAGE_W-1:0] act_page_q;
  logic [PAGE_W-1:0] page_use;
  logic [SUM_W-1:0]  lin_addr;
  logic [ADDR_W-1:0] addr_d;
  logic              we_q;
  logic [ADDR_W-1:0] addr_q;
  logic [7:0]        data_q;

  always_comb begin
    page_use = pkt_start ? page_sel : act_page_q;
    if (cfg_long) lin_addr = {page_use, wr_off};
    else          lin_addr = {1'b0, page_use, wr_off[7:0]};
    addr_d = ADDR_W'(lin_addr);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         act_page_q <= '0;
    else if (pkt_start) act_page_q <= page_sel;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) we_q <= 1'b0;
    else        we_q <= wr_en;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      addr_q <= '0;
      data_q <= '0;
    end else if (wr_en) begin
      addr_q <= addr_d;
      data_q <= wr_data;
    end
  end

  assign ram_we    = we_q;
  assign ram_addr  = addr_q;
  assign ram_wdata = data_q;

  // R8
  addr_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && !pkt_start && wr_off > 9'd3 && $past(wr_en) && !cfg_long)
      |=> (ram_addr[7:0] == 8'($past(wr_off))));
endmodule

// File: rtl/rxpb_host.sv
module rxpb_host #(
  parameter int PAGE_W = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cmd_en,
  input  logic [PAGE_W-1:0] cmd_page,
  input  logic              done,
  input  logic              int_mask,
  output logic [PAGE_W-1:0] page_sel,
  output logic              full,
  output logic              irq
);
  logic              full_q, full_d;
  logic              irq_q, irq_d;
  logic [PAGE_W-1:0] page_q;

  always_comb begin
    full_d = full_q;
    if (done)        full_d = 1'b1;
    else if (cmd_en) full_d = 1'b0;
    irq_d = done & int_mask;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      full_q <= 1'b1;
      irq_q  <= 1'b0;
    end else begin
      full_q <= full_d;
      irq_q  <= irq_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      page_q <= '0;
    else if (cmd_en) page_q <= cmd_page;
  end

  assign page_sel = page_q;
  assign full     = full_q;
  assign irq      = irq_q;

  // R11
  irq_with_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> (full && $rose(full)));

  // R2
  cmd_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_en && !done) |=> !full);

  // R3
  full_holds_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (full && !cmd_en) |=> full);
endmodule

// File: rtl/rx_page_buf.sv
module rx_page_buf
  import rxpb_pkg::*;
#(
  parameter int PAGE_W = 3,
  parameter int ADDR_W = 11
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              rx_valid,
  input  logic              rx_sop,
  input  logic              rx_eop,
  input  logic              rx_err,
  input  logic [7:0]        rx_data,
  input  logic              cmd_en,
  input  logic [PAGE_W-1:0] cmd_page,
  input  logic              cfg_long,
  input  logic              int_mask,
  output logic              ram_we,
  output logic [ADDR_W-1:0] ram_addr,
  output logic [7:0]        ram_wdata,
  output logic              rx_full,
  output logic              irq
);
  logic             wr_en;
  logic [OFF_W-1:0] wr_off;
  logic             pkt_start;
  logic             done;
  logic [PAGE_W-1:0] page_sel;
  logic             full;

  rxpb_parser u_parser (
    .clk       (clk),
    .rst_n     (rst_n),
    .rx_valid  (rx_valid),
    .rx_sop    (rx_sop),
    .rx_eop    (rx_eop),
    .rx_err    (rx_err),
    .rx_data   (rx_data),
    .cfg_long  (cfg_long),
    .full_i    (full),
    .wr_en     (wr_en),
    .wr_off    (wr_off),
    .pkt_start (pkt_start),
    .done      (done)
  );

  rxpb_wr_port #(.PAGE_W(PAGE_W), .ADDR_W(ADDR_W)) u_wr_port (
    .clk       (clk),
    .rst_n     (rst_n),
    .wr_en     (wr_en),
    .wr_off    (wr_off),
    .wr_data   (rx_data),
    .pkt_start (pkt_start),
    .page_sel  (page_sel),
    .cfg_long  (cfg_long),
    .ram_we    (ram_we),
    .ram_addr  (ram_addr),
    .ram_wdata (ram_wdata)
  );

  rxpb_host #(.PAGE_W(PAGE_W)) u_host (
    .clk      (clk),
    .rst_n    (rst_n),
    .cmd_en   (cmd_en),
    .cmd_page (cmd_page),
    .done     (done),
    .int_mask (int_mask),
    .page_sel (page_sel),
    .full     (full),
    .irq      (irq)
  );

  assign rx_full = full;

  // R9
  write_with_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rx_full) |-> ram_we);
endmodule

// File: tb/rx_page_buf_tb.sv
`timescale 1ns/1ps
module rx_page_buf_tb_top;
  localparam int PAGE_W = 3;
  localparam int ADDR_W = 11;

  logic              clk;
  logic              rst_n;
  logic              rx_valid, rx_sop, rx_eop, rx_err;
  logic [7:0]        rx_data;
  logic              cmd_en;
  logic [PAGE_W-1:0] cmd_page;
  logic              cfg_long, int_mask;
  logic              ram_we;
  logic [ADDR_W-1:0] ram_addr;
  logic [7:0]        ram_wdata;
  logic              rx_full, irq;

  rx_page_buf #(.PAGE_W(PAGE_W), .ADDR_W(ADDR_W)) dut_i (
    .clk(clk), .rst_n(rst_n), .rx_valid(rx_valid), .rx_sop(rx_sop),
    .rx_eop(rx_eop), .rx_err(rx_err), .rx_data(rx_data), .cmd_en(cmd_en),
    .cmd_page(cmd_page), .cfg_long(cfg_long), .int_mask(int_mask),
    .ram_we(ram_we), .ram_addr(ram_addr), .ram_wdata(ram_wdata),
    .rx_full(rx_full), .irq(irq)
  );

  initial clk = 1'b0;
  always #2.5 clk = ~clk;

  typedef struct packed {
    logic [ADDR_W-1:0] a;
    logic [7:0]        d;
  } wr_t;

  wr_t        exp_q[$];
  int         n_tests = 0;
  int         n_fail  = 0;
  int         irq_seen = 0;
  bit         exp_full = 1'b1;
  bit         finished = 1'b0;
  logic [7:0] pkt [0:599];
  int         plen;
  int         cur_page;

  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  // scoreboard monitor
  always @(negedge clk) begin
    if (rst_n && !finished) begin
      if (ram_we) begin
        if (exp_q.size() == 0) begin
          check(1'b0, "R3", "unexpected write addr", int'(ram_addr), -1);
        end else begin
          wr_t e;
          e = exp_q.pop_front();
          check(ram_addr == e.a, "R8", "write address", int'(ram_addr), int'(e.a));
          check(ram_wdata == e.d, "R4", "write data", int'(ram_wdata), int'(e.d));
        end
      end
      if (irq) begin
        irq_seen++;
        check(rx_full == 1'b1, "R11", "irq without flag", int'(rx_full), 1);
      end
    end
  end

  task automatic push(input int off, input int idx);
    wr_t e;
    int  a;
    if (cfg_long) a = (cur_page * 512 + off) % (1 << ADDR_W);
    else          a = (cur_page * 256 + off) % (1 << ADDR_W);
    e.a = ADDR_W'(a);
    e.d = pkt[idx];
    exp_q.push_back(e);
  endtask

  // expected writes derived from the header rules
  task automatic model(input bit err, output bit comp);
    bit lp;
    bit stop;
    int nxt;
    int last;
    comp = 1'b0;
    lp   = 1'b0;
    stop = 1'b0;
    nxt  = 0;
    if (exp_full) return;
    for (int i = 0; i < plen; i++) begin
      if (stop) break;
      if (i <= 1) begin
        push(i, i);
      end else if (i == 2) begin
        push(2, 2);
        if (pkt[2] == 8'd0 && cfg_long) lp = 1'b1;
        else if (pkt[2] < 8'd3) stop = 1'b1;
        else nxt = int'(pkt[2]);
      end else if (i == 3 && lp) begin
        push(3, 3);
        if (pkt[3] < 8'd4) stop = 1'b1;
        else nxt = int'(pkt[3]);
      end else begin
        last = lp ? 511 : 255;
        if (nxt > last) begin
          stop = 1'b1;
        end else begin
          push(nxt, i);
          if (i == plen - 1 && nxt == last && !err) comp = 1'b1;
          nxt++;
        end
      end
    end
  endtask

  task automatic build(input int cnt, input int ext, input int ndata);
    int idx;
    pkt[0] = 8'h5A;
    pkt[1] = 8'(cur_page + 8'h20);
    pkt[2] = 8'(cnt);
    idx = 3;
    if (ext >= 0) begin
      pkt[3] = 8'(ext);
      idx = 4;
    end
    for (int i = 0; i < ndata; i++) pkt[idx + i] = 8'(i * 7 + idx + 13);
    plen = idx + ndata;
  endtask

  task automatic send(input bit err, input bit gaps);
    for (int i = 0; i < plen; i++) begin
      @(posedge clk); #1;
      rx_valid = 1'b1;
      rx_sop   = (i == 0);
      rx_eop   = (i == plen - 1);
      rx_err   = err && (i == plen - 1);
      rx_data  = pkt[i];
      if (gaps && (i % 3 == 1)) begin
        @(posedge clk); #1;
        rx_valid = 1'b0;
        rx_sop = 1'b0; rx_eop = 1'b0; rx_err = 1'b0;
      end
    end
    @(posedge clk); #1;
    rx_valid = 1'b0;
    rx_sop = 1'b0; rx_eop = 1'b0; rx_err = 1'b0;
  endtask

  task automatic run_pkt(input bit err, input bit gaps, input string req);
    bit comp;
    int irq0;
    model(err, comp);
    irq0 = irq_seen;
    send(err, gaps);
    repeat (3) @(posedge clk);
    #1;
    check(exp_q.size() == 0, req, "missing writes", exp_q.size(), 0);
    exp_q.delete();
    if (comp) exp_full = 1'b1;
    check(rx_full == exp_full, req, "flag after packet", int'(rx_full), int'(exp_full));
    check(irq_seen - irq0 == ((comp && int_mask) ? 1 : 0), "R11", "irq count",
          irq_seen - irq0, (comp && int_mask) ? 1 : 0);
  endtask

  task automatic host_enable(input int page);
    @(posedge clk); #1;
    cmd_en = 1'b1;
    cmd_page = PAGE_W'(page);
    @(posedge clk); #1;
    cmd_en = 1'b0;
    cur_page = page;
    exp_full = 1'b0;
    check(rx_full == 1'b0, "R2", "flag after enable", int'(rx_full), 0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      finished = 1'b1;
      n_fail++;
      $display("FAIL watchdog expired");
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0;
    rx_valid = 1'b0; rx_sop = 1'b0; rx_eop = 1'b0; rx_err = 1'b0;
    rx_data = '0; cmd_en = 1'b0; cmd_page = '0;
    cfg_long = 1'b0; int_mask = 1'b1;
    cur_page = 0;
    repeat (3) @(posedge clk);
    #1;
    rst_n = 1'b1;
    // R1
    check(rx_full == 1'b1, "R1", "flag at reset", int'(rx_full), 1);
    check(irq == 1'b0, "R1", "irq at reset", int'(irq), 0);
    check(ram_we == 1'b0, "R1", "write at reset", int'(ram_we), 0);

    // R3: packet while flag is set is ignored
    build(250, -1, 6);
    run_pkt(1'b0, 1'b0, "R3");

    // R5 R9 R11: short packet, page 2, interrupt enabled
    host_enable(2);
    build(250, -1, 6);
    run_pkt(1'b0, 1'b1, "R9");

    // R3: ignored while full
    build(253, -1, 3);
    run_pkt(1'b0, 1'b0, "R3");

    // R11: mask off, page 5
    int_mask = 1'b0;
    host_enable(5);
    build(253, -1, 3);
    run_pkt(1'b0, 1'b0, "R5");
    int_mask = 1'b1;

    // R10: early end, then overrun, then error
    host_enable(1);
    build(250, -1, 5);
    run_pkt(1'b0, 1'b0, "R10");
    build(250, -1, 8);
    run_pkt(1'b0, 1'b0, "R10");
    build(250, -1, 6);
    run_pkt(1'b1, 1'b0, "R10");

    // R5: count byte 2 invalid
    build(2, -1, 4);
    run_pkt(1'b0, 1'b0, "R5");

    // R7: zero count with long disabled
    build(0, 250, 6);
    run_pkt(1'b0, 1'b0, "R7");

    // R6: long packet on page 3
    cfg_long = 1'b1;
    host_enable(3);
    build(0, 250, 262);
    run_pkt(1'b0, 1'b1, "R6");

    // R8: page 6 wraps within the RAM in long mode
    host_enable(6);
    build(0, 252, 260);
    run_pkt(1'b0, 1'b0, "R8");

    // R6: short packet in long mode ends at 255
    host_enable(4);
    build(252, -1, 4);
    run_pkt(1'b0, 1'b0, "R6");

    // R6: extended byte below 4 invalid
    host_enable(0);
    build(0, 3, 5);
    run_pkt(1'b0, 1'b0, "R6");

    repeat (5) @(posedge clk);
    finished = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule